// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block keeps a free-running tick counter and watches one of its bits, chosen by a two-bit period code. Each time the watched bit goes from 0 to 1, the watchdog reaches the end of a period. What happens then depends on two status flags. The first expiry after a quiet period sets the "warned" flag. The next expiry sets the "interrupt" flag and can raise an interrupt line. The expiry after that records the chosen reset kind in the status field and sends a one-cycle request on the matching reset output. After that the watchdog stays parked.

Software keeps the watchdog quiet by writing ones to the two flag bits of the clear input. Each written one clears that flag. The period code, the reset kind and the interrupt enable are static control inputs, sampled at the expiry that uses them. The reset requests are only requests: the logic that performs the reset is outside this block.

Top module: `wdog_escalator`

## Requirements
- R1: After reset, both stage flags, the reset-kind field, the interrupt output and all three reset request outputs are 0, and the tick counter is 0.
- R2: Period code c selects P = PER_BASE + c*PER_STEP. An expiry is a cycle with tick_i high in which the low P bits of the counter equal 2^(P-1)-1. The counter advances by one only in cycles with tick_i high. So the first expiry after reset falls on tick 2^(P-1), and later ones follow every 2^P ticks.
- R3: An expiry with the stage flags {warned, irq} at 00 or 01 sets the warned flag, which shows on stat_next_o one cycle after the expiry cycle.
- R4: An expiry with the flags at 10 sets the irq flag (stat_irq_o). If irq_en_i is 1 in that cycle, irq_o also rises. irq_o then stays high until the irq flag is cleared.
- R5: An expiry with the flags at 11 copies rst_sel_i into stat_kind_o and, in the same following cycle, pulses one reset output for exactly one cycle: code 1 drives rst_core_o, code 2 drives rst_chip_o and code 3 drives rst_sys_o. Code 0 pulses none of them.
- R6: After the R5 action the watchdog is parked. Later expiries change nothing until a clear write leaves both flags at 0.
- R7: Clear bit 1 of stat_clr_i clears the warned flag. Clear bit 0 clears the irq flag and irq_o. A zero bit has no effect. If a clear and an expiry fall in the same cycle, the clear is applied first and the expiry acts on the cleared flags.
- R8: At most one reset request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter advance enable |
| per_sel_i | input | 2 | Period code |
| rst_sel_i | input | 2 | Reset kind to request on final expiry |
| irq_en_i | input | 1 | Interrupt enable for the second stage |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 1 warned flag, bit 0 irq flag |
| stat_next_o | output | 1 | Warned flag |
| stat_irq_o | output | 1 | Interrupt status flag |
| stat_kind_o | output | 2 | Last requested reset kind |
| irq_o | output | 1 | Interrupt request level |
| rst_core_o | output | 1 | Core reset request pulse |
| rst_chip_o | output | 1 | Chip reset request pulse |
| rst_sys_o | output | 1 | System reset request pulse |

## Verification
A wrong stage flag shows at the ports at the next expiry: the wrong step of the escalation fires, for example an early reset pulse or a missing interrupt, within one period of the fault. A wrong counter phase moves every expiry by a fixed number of ticks, so the first flag change after reset comes on the wrong cycle. A parked state that is lost or kept too long shows as a reset pulse that should not happen, or as flags that fail to move after a clear, within one period. The bench compares every output against a cycle model on every cycle, so each of these faults is reported in the first cycle it shows.

// File: rtl/wdog_esc_pkg.sv
package wdog_esc_pkg;

   localparam int N_PER_CODES = 4;
   localparam int N_RST_KINDS = 4;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_CORE = 2'd1,
      RK_CHIP = 2'd2,
      RK_SYS  = 2'd3
   } rst_kind_e;

   typedef struct packed {
      logic warned;
      logic irqs;
   } stage_t;

endpackage

// File: rtl/wdog_esc_tickbase.sv
module wdog_esc_tickbase
   import wdog_esc_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int PER_BASE = 17,
   parameter int PER_STEP = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic [1:0] per_sel_i,
   output logic       expire_o
);

   localparam int TOP_BIT = PER_BASE + (N_PER_CODES - 1) * PER_STEP;

   if (PER_BASE < 2) begin : g_bad_base
      $error("PER_BASE must be at least 2");
   end
   if (PER_STEP < 1) begin : g_bad_step
      $error("PER_STEP must be at least 1");
   end
   if (TOP_BIT > CNT_W) begin : g_bad_width
      $error("longest period does not fit in CNT_W");
   end

   logic [CNT_W-1:0]       cnt_q;
   logic [N_PER_CODES-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, tick_i};
      end
   end

   // One comparator per period code: low LB bits sit just below the
   // point where bit LB-1 goes from 0 to 1.
   for (genvar g = 0; g < N_PER_CODES; g++) begin : g_per
      localparam int LB = PER_BASE + g * PER_STEP;
      assign hit[g] = (cnt_q[LB-1:0] == {1'b0, {(LB-1){1'b1}}});
   end

   assign expire_o = tick_i & hit[per_sel_i];

endmodule

// File: rtl/wdog_esc_stage.sv
module wdog_esc_stage
   import wdog_esc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire_i,
   input  logic       irq_en_i,
   input  logic [1:0] rst_sel_i,
   input  logic [1:0] clr_i,
   output logic       warned_o,
   output logic       irqs_o,
   output logic [1:0] kind_o,
   output logic       irq_o,
   output logic       fire_o
);

   stage_t    stage_q, stage_eff, stage_d;
   rst_kind_e kind_q, kind_d;
   logic      park_q, park_d;
   logic      irq_q, irq_d;
   logic      fire_q, fire_d;
   logic      rearm;

   always_comb begin
      stage_eff.warned = stage_q.warned & ~clr_i[1];
      stage_eff.irqs   = stage_q.irqs   & ~clr_i[0];
      rearm            = (|clr_i) & ~stage_eff.warned & ~stage_eff.irqs;
      park_d           = park_q & ~rearm;
      stage_d          = stage_eff;
      kind_d           = kind_q;
      irq_d            = irq_q & ~clr_i[0];
      fire_d           = 1'b0;
      if (expire_i && !park_d) begin
         unique case ({stage_eff.warned, stage_eff.irqs})
            2'b00, 2'b01: stage_d.warned = 1'b1;
            2'b10: begin
               stage_d.irqs = 1'b1;
               if (irq_en_i) begin
                  irq_d = 1'b1;
               end
            end
            default: begin
               kind_d = rst_kind_e'(rst_sel_i);
               fire_d = 1'b1;
               park_d = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         kind_q  <= RK_NONE;
         park_q  <= 1'b0;
         irq_q   <= 1'b0;
         fire_q  <= 1'b0;
      end else begin
         stage_q <= stage_d;
         kind_q  <= kind_d;
         park_q  <= park_d;
         irq_q   <= irq_d;
         fire_q  <= fire_d;
      end
   end

   assign warned_o = stage_q.warned;
   assign irqs_o   = stage_q.irqs;
   assign kind_o   = kind_q;
   assign irq_o    = irq_q;
   assign fire_o   = fire_q;

endmodule

// File: rtl/wdog_esc_rstreq.sv
module wdog_esc_rstreq
   import wdog_esc_pkg::*;
(
   input  logic                   fire_i,
   input  logic [1:0]             kind_i,
   output logic [N_RST_KINDS-2:0] req_o
);

   // Kind 0 requests nothing; kinds 1..3 map to one request line each.
   for (genvar k = 1; k < N_RST_KINDS; k++) begin : g_req
      assign req_o[k-1] = fire_i & (kind_i == 2'(k));
   end

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
   import wdog_esc_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int PER_BASE = 17,
   parameter int PER_STEP = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic [1:0] per_sel_i,
   input  logic [1:0] rst_sel_i,
   input  logic       irq_en_i,
   input  logic [1:0] stat_clr_i,
   output logic       stat_next_o,
   output logic       stat_irq_o,
   output logic [1:0] stat_kind_o,
   output logic       irq_o,
   output logic       rst_core_o,
   output logic       rst_chip_o,
   output logic       rst_sys_o
);

   logic                   expire;
   logic                   fire;
   logic [N_RST_KINDS-2:0] req;

   wdog_esc_tickbase #(
      .CNT_W    (CNT_W),
      .PER_BASE (PER_BASE),
      .PER_STEP (PER_STEP)
   ) i_tickbase (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .per_sel_i (per_sel_i),
      .expire_o  (expire)
   );

   wdog_esc_stage i_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire_i  (expire),
      .irq_en_i  (irq_en_i),
      .rst_sel_i (rst_sel_i),
      .clr_i     (stat_clr_i),
      .warned_o  (stat_next_o),
      .irqs_o    (stat_irq_o),
      .kind_o    (stat_kind_o),
      .irq_o     (irq_o),
      .fire_o    (fire)
   );

   wdog_esc_rstreq i_rstreq (
      .fire_i (fire),
      .kind_i (stat_kind_o),
      .req_o  (req)
   );

   assign rst_core_o = req[0];
   assign rst_chip_o = req[1];
   assign rst_sys_o  = req[2];

endmodule

// File: rtl/wdog_esc_chk.sv
module wdog_esc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stat_next_o,
   input logic       stat_irq_o,
   input logic [1:0] stat_kind_o,
   input logic       irq_o,
   input logic       rst_core_o,
   input logic       rst_chip_o,
   input logic       rst_sys_o
);

   logic any_req;
   assign any_req = rst_core_o | rst_chip_o | rst_sys_o;

   // R8
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_core_o, rst_chip_o, rst_sys_o}));

   // R5
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |=> !any_req);

   // R5
   req_after_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> (stat_next_o && stat_irq_o));

   // R5
   req_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> (stat_kind_o == {rst_chip_o | rst_sys_o, rst_core_o | rst_sys_o}));

   // R4
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> stat_irq_o);

   // R3
   irq_after_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_irq_o) |-> $past(stat_next_o));

endmodule

bind wdog_escalator wdog_esc_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_next_o (stat_next_o),
   .stat_irq_o  (stat_irq_o),
   .stat_kind_o (stat_kind_o),
   .irq_o       (irq_o),
   .rst_core_o  (rst_core_o),
   .rst_chip_o  (rst_chip_o),
   .rst_sys_o   (rst_sys_o)
);

// File: tb/test_wdog_escalator.sv
module test_wdog_escalator;

   localparam int PB = 3;
   localparam int PS = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [1:0] per_sel_i = 2'd0;
   logic [1:0] rst_sel_i = 2'd0;
   logic       irq_en_i = 1'b0;
   logic [1:0] stat_clr_i = 2'd0;
   logic       stat_next_o, stat_irq_o, irq_o;
   logic [1:0] stat_kind_o;
   logic       rst_core_o, rst_chip_o, rst_sys_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state
   logic [63:0] m_cnt;
   logic        m_nxt, m_irqs, m_irq, m_park, m_fire;
   logic [1:0]  m_kind;

   always #10 clk = ~clk;

   wdog_escalator #(.CNT_W(64), .PER_BASE(PB), .PER_STEP(PS)) i_wdog_escalator (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .per_sel_i(per_sel_i),
      .rst_sel_i(rst_sel_i), .irq_en_i(irq_en_i), .stat_clr_i(stat_clr_i),
      .stat_next_o(stat_next_o), .stat_irq_o(stat_irq_o), .stat_kind_o(stat_kind_o),
      .irq_o(irq_o), .rst_core_o(rst_core_o), .rst_chip_o(rst_chip_o), .rst_sys_o(rst_sys_o)
   );

   function automatic bit is_expiry(input logic [63:0] cnt, input logic [1:0] code, input logic tk);
      int p = PB + PS * int'(code);
      logic [63:0] mask = (64'd1 << p) - 64'd1;
      return tk && ((cnt & mask) == ((64'd1 << (p - 1)) - 64'd1));
   endfunction

   task automatic model_step();
      logic e_nxt, e_irqs, ex;
      if (!rst_n) begin
         m_cnt = '0; m_nxt = 0; m_irqs = 0; m_irq = 0; m_park = 0; m_fire = 0; m_kind = 0;
         return;
      end
      ex     = is_expiry(m_cnt, per_sel_i, tick_i);
      e_nxt  = m_nxt  & ~stat_clr_i[1];
      e_irqs = m_irqs & ~stat_clr_i[0];
      if (stat_clr_i != 2'b00 && !e_nxt && !e_irqs) m_park = 0;
      m_nxt  = e_nxt;
      m_irqs = e_irqs;
      m_irq  = m_irq & ~stat_clr_i[0];
      m_fire = 0;
      if (ex && !m_park) begin
         if (!e_nxt) m_nxt = 1;
         else if (!e_irqs) begin
            m_irqs = 1;
            if (irq_en_i) m_irq = 1;
         end else begin
            m_kind = rst_sel_i; m_fire = 1; m_park = 1;
         end
      end
      m_cnt = m_cnt + 64'(tick_i);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R3", "warned flag", int'(stat_next_o), int'(m_nxt));
      chk("R4", "irq flag", int'(stat_irq_o), int'(m_irqs));
      chk("R4", "irq line", int'(irq_o), int'(m_irq));
      chk("R5", "kind field", int'(stat_kind_o), int'(m_kind));
      chk("R5", "core req", int'(rst_core_o), int'(m_fire && m_kind == 2'd1));
      chk("R5", "chip req", int'(rst_chip_o), int'(m_fire && m_kind == 2'd2));
      chk("R5", "sys req", int'(rst_sys_o), int'(m_fire && m_kind == 2'd3));
      chk("R8", "request count", int'(rst_core_o) + int'(rst_chip_o) + int'(rst_sys_o) > 1 ? 1 : 0, 0);
   endtask

   task automatic cyc();
      @(negedge clk);
      model_step();
      compare_all();
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd7;
      void'($urandom(seed));
      repeat (3) cyc();
      // R1: reset state
      chk("R1", "outputs in reset", int'({stat_next_o, stat_irq_o, stat_kind_o, irq_o,
                                         rst_core_o, rst_chip_o, rst_sys_o}), 0);
      rst_n = 1'b1;
      cyc();
      chk("R1", "outputs after reset", int'({stat_next_o, stat_irq_o, stat_kind_o, irq_o}), 0);

      // R2/R3: code 0 -> P=3, first expiry on tick 4
      per_sel_i = 2'd0; irq_en_i = 1'b1; rst_sel_i = 2'd2; tick_i = 1'b1;
      repeat (3) cyc();
      chk("R2", "no expiry before tick 4", int'(stat_next_o), 0);
      cyc();
      chk("R3", "warned after first expiry", int'(stat_next_o), 1);

      // R4: next expiry 8 ticks later
      repeat (7) cyc();
      chk("R2", "irq flag not early", int'(stat_irq_o), 0);
      cyc();
      chk("R4", "irq flag set", int'(stat_irq_o), 1);
      chk("R4", "irq raised with enable", int'(irq_o), 1);

      // R5: third expiry requests chip reset
      repeat (8) cyc();
      chk("R5", "chip request pulse", int'(rst_chip_o), 1);
      chk("R5", "kind recorded", int'(stat_kind_o), 2);
      cyc();
      chk("R5", "pulse lasts one cycle", int'(rst_chip_o), 0);

      // R6: parked, two expiries pass with no effect
      for (int i = 0; i < 16; i++) begin
         cyc();
         chk("R6", "no request while parked", int'(rst_core_o | rst_chip_o | rst_sys_o), 0);
      end
      chk("R6", "flags held while parked", int'({stat_next_o, stat_irq_o}), 3);

      // R2: no tick, nothing moves
      tick_i = 1'b0;
      stat_clr_i = 2'b11;
      cyc();
      stat_clr_i = 2'b00;
      chk("R7", "clear both flags", int'({stat_next_o, stat_irq_o, irq_o}), 0);
      repeat (40) cyc();
      chk("R2", "no tick holds state", int'({stat_next_o, stat_irq_o}), 0);

      // R7: zero clear bits have no effect; rearm works
      tick_i = 1'b1;
      repeat (12) cyc();
      chk("R6", "rearmed after clear", int'(stat_next_o), 1);

      // random phase checked against the model every cycle
      for (int i = 0; i < 30000; i++) begin
         tick_i     = ($urandom % 4) != 0;
         if (($urandom % 400) == 0) per_sel_i = 2'($urandom);
         if (($urandom % 50) == 0)  irq_en_i  = ~irq_en_i;
         rst_sel_i  = 2'($urandom);
         stat_clr_i = {($urandom % 30) == 0, ($urandom % 30) == 0};
         cyc();
      end
      // R7: clear in the same cycle as expiry — directed
      stat_clr_i = 2'b00;
      rst_n = 1'b0; cyc(); rst_n = 1'b1;
      per_sel_i = 2'd0; tick_i = 1'b1;
      repeat (4) cyc();
      repeat (7) cyc();
      stat_clr_i = 2'b10;
      cyc();
      stat_clr_i = 2'b00;
      chk("R7", "clear before expiry re-warns", int'({stat_next_o, stat_irq_o}), 2);

      done = 1'b1;
      report();
      $finish;
   end

endmodule